// File: doc/BRIEF.md
# Video Controller Host Register File

This block is the processor-facing register file of a raster video controller. The host sees two byte-wide ports, chosen by `host_sel`. The index/status port (`host_sel` = 0) takes a register number when written. When read, it returns status. The data port (`host_sel` = 1) writes or reads the register that the index selects. Configuration registers 0 to 15 feed the timing generator through a parallel export bus. A host write lands in a shadow copy first. That copy is moved to the export bus only on a character-clock enable, so the timing logic never sees a value change in the middle of a character.

The block also captures the light pen position. A rising edge on the pen strobe copies the current 14-bit refresh address into two read-only registers, 16 (high part) and 17 (low part), and raises a pen flag. A build-time parameter sets how much the host can read back:

- the full option, with every register and the status bits;
- the basic option, with only the cursor and pen registers;
- the write-only option, where nothing can be read.

The host port has no back-pressure. Every access is accepted in the cycle it is presented, and the read result follows one cycle later.

Top module: `vtc_host_regs`

## Requirements
- R1: Writing the index port stores `host_wdata[4:0]` as the register index. A later data-port write goes to the register with that index.
- R2: A data-port write to registers 0 to 15 updates the shadow copy at once. `cfg_out` (register n at bits [8n+7:8n]) takes the new value at the first clock edge with `char_en` high that comes after the write edge. Without `char_en`, `cfg_out` holds.
- R3: In the full option, an index-port read returns {bit7 = 0 (self-test, always passes as 0), bit6 = pen flag, bit5 = `vsync_in` sampled at the read edge, bits 4..0 = 0}.
- R4: A rising edge of `lpen_strobe`, sampled on the clock, latches `ref_addr[13:8]` into register 16 (bits 7..6 read 0) and `ref_addr[7:0]` into register 17, and sets the pen flag.
- R5: A data-port read of register 17 clears the pen flag. A read of register 16 leaves it set. If a strobe edge arrives in the same cycle as the clearing read, the flag stays set.
- R6: Writes to registers 16, 17 and to indices 18 to 31 are ignored. Reads of indices 18 to 31 return 0.
- R7: In the full option, registers 0 to 17 can all be read back. Registers 12 and 14 store and return only their low 6 bits, because start and cursor addresses are 14 bits wide.
- R8: In the basic option, only registers 14 to 17 can be read. Every other data-port read, and every index-port read, returns 0.
- R9: In the write-only option, every read of either port returns 0, so the pen position cannot be read by the host.
- R10: `host_rdata` is registered. It carries the read result in the cycle after `host_rd`, and 0 after any cycle without a read and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the index/status port, 1 selects the data port |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| char_en | input | 1 | Character-clock enable that moves the shadow copy onto the export bus |
| lpen_strobe | input | 1 | Light pen strobe level |
| ref_addr | input | 14 | Current refresh address from the timing block |
| vsync_in | input | 1 | Live vertical sync level |
| cfg_out | output | 128 | Exported registers 0 to 15, register n at bits [8n+7:8n] |

## Verification
A read result is due exactly one clock after the `host_rd` edge. A shadow write shows on `cfg_out` at the first `char_en` edge after it. A pen capture or flag change is visible to a read issued in the next cycle. The bench drives the inputs on the falling edge. A behavioural model, updated at each rising edge with the same one-register latency, is compared with `host_rdata` and `cfg_out` of all three readback options at every falling edge. This way each result is checked in the cycle it becomes due, and in no other cycle.

// File: rtl/vtc_regs_pkg.sv
package vtc_regs_pkg;
  localparam int unsigned VAR_FULL  = 0;
  localparam int unsigned VAR_BASIC = 1;
  localparam int unsigned VAR_NONE  = 2;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned N_CFG    = 16;
  localparam int unsigned ADDR_W   = 14;
  localparam int unsigned IDX_LPHI = 16;
  localparam int unsigned IDX_LPLO = 17;
  localparam int unsigned IDX_CUR  = 14;
  localparam int unsigned IDX_STA  = 12;

  // 14-bit address high bytes keep six bits
  function automatic logic [DATA_W-1:0] field_mask(int unsigned idx);
    if (idx == IDX_STA || idx == IDX_CUR) return 8'h3F;
    return 8'hFF;
  endfunction

  function automatic logic is_readable(int unsigned variant, int unsigned idx);
    case (variant)
      VAR_FULL:  return idx <= IDX_LPLO;
      VAR_BASIC: return idx >= IDX_CUR && idx <= IDX_LPLO;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vtc_cfg_bank.sv
module vtc_cfg_bank
  import vtc_regs_pkg::*;
#(
  parameter int unsigned NREG = N_CFG,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned IW   = IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             char_en,
  output logic [NREG*DW-1:0] shadow_flat,
  output logic [NREG*DW-1:0] cfg_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = field_mask(g);
    logic [DW-1:0] shadow_q;
    logic [DW-1:0] live_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q <= '0;
        live_q   <= '0;
      end else begin
        if (wr_en && wr_idx == IW'(g)) shadow_q <= wr_data & MASK;
        if (char_en) live_q <= shadow_q;
      end
    end

    assign shadow_flat[g*DW +: DW] = shadow_q;
    assign cfg_flat[g*DW +: DW]    = live_q;
  end
endmodule

// File: rtl/vtc_lpen_latch.sv
module vtc_lpen_latch
  import vtc_regs_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] ref_addr,
  input  logic          clr_req,
  output logic [DW-1:0] lp_hi,
  output logic [DW-1:0] lp_lo,
  output logic          flag,
  output logic          edge_o
);
  localparam int unsigned HI_W = AW - DW;

  logic strobe_q;
  assign edge_o = strobe && !strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      lp_hi    <= '0;
      lp_lo    <= '0;
      flag     <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (edge_o) begin
        lp_hi <= DW'(ref_addr[AW-1:DW]);
        lp_lo <= ref_addr[DW-1:0];
        flag  <= 1'b1;
      end else if (clr_req) begin
        flag <= 1'b0;
      end
    end
  end

  if (HI_W > DW) begin : g_bad_width
    initial $display("vtc_lpen_latch: address wider than two bytes");
  end
endmodule

// File: rtl/vtc_read_mux.sv
module vtc_read_mux
  import vtc_regs_pkg::*;
#(
  parameter int unsigned VARIANT = VAR_FULL,
  parameter int unsigned NREG    = N_CFG,
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned IW      = IDX_W
) (
  input  logic               port_sel,
  input  logic [IW-1:0]      idx,
  input  logic [NREG*DW-1:0] shadow_flat,
  input  logic [DW-1:0]      lp_hi,
  input  logic [DW-1:0]      lp_lo,
  input  logic               lp_flag,
  input  logic               vsync,
  output logic [DW-1:0]      rd_value
);
  localparam int unsigned RIW = $clog2(NREG);

  logic [DW-1:0] bank [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign bank[g] = shadow_flat[g*DW +: DW];
  end

  logic [DW-1:0] status;
  logic [DW-1:0] reg_val;

  always_comb begin
    status = '0;
    status[DW-2] = lp_flag;
    status[DW-3] = vsync;

    if (int'(idx) < NREG)          reg_val = bank[idx[RIW-1:0]];
    else if (int'(idx) == IDX_LPHI) reg_val = lp_hi;
    else if (int'(idx) == IDX_LPLO) reg_val = lp_lo;
    else                            reg_val = '0;

    if (!port_sel)
      rd_value = (VARIANT == VAR_FULL) ? status : '0;
    else
      rd_value = is_readable(VARIANT, int'(idx)) ? reg_val : '0;
  end
endmodule

// File: rtl/vtc_host_regs.sv
module vtc_host_regs
  import vtc_regs_pkg::*;
#(
  parameter int unsigned VARIANT = VAR_FULL
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_sel,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  input  logic                    char_en,
  input  logic                    lpen_strobe,
  input  logic [ADDR_W-1:0]       ref_addr,
  input  logic                    vsync_in,
  output logic [N_CFG*DATA_W-1:0] cfg_out
);
  logic [IDX_W-1:0]        reg_idx;
  logic [N_CFG*DATA_W-1:0] shadow_flat;
  logic [DATA_W-1:0]       lp_hi, lp_lo, rd_value;
  logic                    lpen_flag, lp_edge;
  logic                    cfg_we, lp_clr;

  assign cfg_we = host_wr && host_sel && (int'(reg_idx) < N_CFG);
  assign lp_clr = host_rd && host_sel && (int'(reg_idx) == IDX_LPLO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_idx    <= '0;
      host_rdata <= '0;
    end else begin
      if (host_wr && !host_sel) reg_idx <= host_wdata[IDX_W-1:0];
      host_rdata <= host_rd ? rd_value : '0;
    end
  end

  vtc_cfg_bank #(.NREG(N_CFG), .DW(DATA_W), .IW(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(reg_idx),
    .wr_data(host_wdata), .char_en(char_en),
    .shadow_flat(shadow_flat), .cfg_flat(cfg_out)
  );

  vtc_lpen_latch #(.AW(ADDR_W), .DW(DATA_W)) u_lpen (
    .clk(clk), .rst_n(rst_n), .strobe(lpen_strobe), .ref_addr(ref_addr),
    .clr_req(lp_clr), .lp_hi(lp_hi), .lp_lo(lp_lo), .flag(lpen_flag),
    .edge_o(lp_edge)
  );

  vtc_read_mux #(.VARIANT(VARIANT), .NREG(N_CFG), .DW(DATA_W), .IW(IDX_W)) u_rmux (
    .port_sel(host_sel), .idx(reg_idx), .shadow_flat(shadow_flat),
    .lp_hi(lp_hi), .lp_lo(lp_lo), .lp_flag(lpen_flag), .vsync(vsync_in),
    .rd_value(rd_value)
  );
endmodule

// File: rtl/vtc_host_regs_chk.sv
module vtc_host_regs_chk
  import vtc_regs_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    host_sel,
  input logic                    host_wr,
  input logic                    host_rd,
  input logic [DATA_W-1:0]       host_rdata,
  input logic                    char_en,
  input logic [N_CFG*DATA_W-1:0] cfg_out,
  input logic [IDX_W-1:0]        reg_idx,
  input logic                    lp_edge,
  input logic                    lpen_flag,
  input logic [DATA_W-1:0]       lp_hi,
  input logic [DATA_W-1:0]       lp_lo
);
  AST_EXPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !char_en |=> $stable(cfg_out)); // R2
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel) |=> host_rdata[4:0] == 5'd0); // R3
  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    lp_edge |=> lpen_flag); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel && int'(reg_idx) == IDX_LPLO && !lp_edge) |=> !lpen_flag); // R5
  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && int'(reg_idx) >= IDX_LPHI && !lp_edge)
      |=> ($stable(lp_hi) && $stable(lp_lo))); // R6
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> host_rdata == '0); // R10
endmodule

bind vtc_host_regs vtc_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .char_en(char_en),
  .cfg_out(cfg_out), .reg_idx(reg_idx), .lp_edge(lp_edge),
  .lpen_flag(lpen_flag), .lp_hi(lp_hi), .lp_lo(lp_lo)
);

// File: tb/vtc_host_regs_test.sv
module vtc_host_regs_test;
  import vtc_regs_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic char_en = 1'b1, lpen_strobe = 1'b0, vsync_in = 1'b0;
  logic [13:0] ref_addr = '0;
  logic [7:0] rd_v [3];
  logic [127:0] cfg_v [3];

  always #10 clk = ~clk;

  vtc_host_regs #(.VARIANT(VAR_FULL)) uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(rd_v[0]),
    .char_en(char_en), .lpen_strobe(lpen_strobe), .ref_addr(ref_addr),
    .vsync_in(vsync_in), .cfg_out(cfg_v[0]));
  vtc_host_regs #(.VARIANT(VAR_BASIC)) uut_basic (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(rd_v[1]),
    .char_en(char_en), .lpen_strobe(lpen_strobe), .ref_addr(ref_addr),
    .vsync_in(vsync_in), .cfg_out(cfg_v[1]));
  vtc_host_regs #(.VARIANT(VAR_NONE)) uut_none (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(rd_v[2]),
    .char_en(char_en), .lpen_strobe(lpen_strobe), .ref_addr(ref_addr),
    .vsync_in(vsync_in), .cfg_out(cfg_v[2]));

  int checks = 0, errors = 0;
  string cur_req = "R10";

  // behavioural model
  int m_idx;
  int m_shadow [16];
  int m_live [16];
  int m_hi, m_lo;
  bit m_flag, m_lpq;
  int m_rd [3];

  function automatic int model_read(int v, bit sel, int idx);
    if (!sel) return (v == 0) ? ((int'(m_flag) << 6) | (int'(vsync_in) << 5)) : 0;
    if (v == 2) return 0;
    if (v == 1 && (idx < 14 || idx > 17)) return 0;
    if (idx < 16) return m_shadow[idx];
    if (idx == 16) return m_hi;
    if (idx == 17) return m_lo;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_hi = 0; m_lo = 0; m_flag = 0; m_lpq = 0;
      for (int i = 0; i < 16; i++) begin m_shadow[i] = 0; m_live[i] = 0; end
      for (int v = 0; v < 3; v++) m_rd[v] = 0;
    end else begin
      for (int v = 0; v < 3; v++) m_rd[v] = host_rd ? model_read(v, host_sel, m_idx) : 0;
      if (char_en) for (int i = 0; i < 16; i++) m_live[i] = m_shadow[i];
      if (host_rd && host_sel && m_idx == 17) m_flag = 0;
      if (lpen_strobe && !m_lpq) begin
        m_hi = int'(ref_addr) >> 8; m_lo = int'(ref_addr) & 255; m_flag = 1;
      end
      m_lpq = lpen_strobe;
      if (host_wr) begin
        if (!host_sel) m_idx = int'(host_wdata) & 31;
        else if (m_idx < 16)
          m_shadow[m_idx] = int'(host_wdata) & ((m_idx == 12 || m_idx == 14) ? 63 : 255);
      end
    end
  end

  always @(negedge clk) begin
    for (int v = 0; v < 3; v++) begin
      checks++;
      if (int'(rd_v[v]) != m_rd[v]) begin
        errors++;
        $display("FAIL %s rdata option %0d: got %h expected %h", cur_req, v, rd_v[v], m_rd[v]);
      end
      for (int i = 0; i < 16; i++) begin
        if (int'(cfg_v[v][i*8 +: 8]) != m_live[i]) begin
          errors++;
          $display("FAIL %s cfg_out option %0d reg %0d: got %h expected %h",
                   cur_req, v, i, cfg_v[v][i*8 +: 8], m_live[i]);
        end
      end
    end
  end

  task automatic access(bit sel, bit wr, int data);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_rd = !wr; host_wdata = 8'(data);
    @(negedge clk);
    host_wr = 0; host_rd = 0;
  endtask

  task automatic wreg(int idx, int data);
    access(0, 1, idx);
    access(1, 1, data);
  endtask

  task automatic rreg(int idx);
    access(0, 1, idx);
    access(1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R10";               // reset state and idle output
    rst_n = 1;
    repeat (2) @(negedge clk);

    cur_req = "R1";
    wreg(3, 8'hA5);
    rreg(3);

    cur_req = "R2";
    char_en = 0;
    wreg(5, 8'h3C);
    wreg(0, 8'h71);
    repeat (3) @(negedge clk);
    char_en = 1;
    @(negedge clk);
    char_en = 0;
    wreg(6, 8'h99);
    char_en = 1;

    cur_req = "R7";
    for (int i = 0; i < 16; i++) wreg(i, i * 17 + 200);
    for (int i = 0; i < 18; i++) rreg(i);

    cur_req = "R3";
    vsync_in = 0; access(0, 0, 0);
    vsync_in = 1; access(0, 0, 0);
    vsync_in = 0;

    cur_req = "R4";
    ref_addr = 14'h2ABC;
    @(negedge clk); lpen_strobe = 1;
    @(negedge clk); ref_addr = 14'h0123;
    repeat (2) @(negedge clk); lpen_strobe = 0;
    access(0, 0, 0);
    rreg(16);

    cur_req = "R5";
    access(0, 0, 0);
    rreg(17);
    access(0, 0, 0);
    access(0, 1, 17);
    ref_addr = 14'h3FFF;
    @(negedge clk);
    host_sel = 1; host_rd = 1; lpen_strobe = 1;
    @(negedge clk);
    host_rd = 0; lpen_strobe = 0;
    access(0, 0, 0);

    cur_req = "R6";
    wreg(16, 8'h11);
    wreg(17, 8'h22);
    wreg(21, 8'h33);
    rreg(16); rreg(17); rreg(21); rreg(31);

    cur_req = "R8";
    rreg(12); rreg(14); rreg(15);
    cur_req = "R9";
    rreg(17); access(0, 0, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule